// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit up counters that share one 9-bit free-running prescaler. The prescaler advances on a single base clock enable supplied from outside. It offers four tick enables, at the base rate divided by 2, 8, 32 and 512. Each counter has its own run bit, its own 2-bit source select and its own 8-bit compare value. When a counter reaches its compare value, it raises a one-cycle match pulse and restarts from zero on its next count.

The first counter counts either rising edges of an external pin or one of three prescaler taps. The second counter has a different set of sources. In 8-bit mode it counts prescaler taps or the first counter's match events. In cascade mode it counts the first counter's wrap-arounds, so the pair acts as one 16-bit timer with a 16-bit compare. Software-facing registers are kept outside: the run bits, selects, mode and compare values arrive as plain inputs. The live counts are brought out so that run control can be observed.

Top module: `dual_interval_timer`

## Requirements
- R1: The 9-bit prescaler advances once per base tick while `pre_run_i` is 1 and is held at zero while it is 0. Its taps fire on the base tick that completes every 2nd, 8th, 32nd and 512th base tick counted from zero, so the first /32 tick arrives on the 32nd base tick after a restart.
- R2: The first counter's source code on `src0_sel_i` is 00 for rising edges of the external pin, 01 for base/2, 10 for base/8 and 11 for base/32.
- R3: In 8-bit mode (`cascade_i`=0), the second counter's source code on `src1_sel_i` is 00 for first-counter match events, 01 for base/2, 10 for base/32 and 11 for base/512.
- R4: A counter whose run bit is 0 reads zero one cycle later and stays at zero. Clearing one counter's run bit does not disturb the other counter or the prescaler.
- R5: In 8-bit mode, a counter that receives a count while equal to its compare value returns to zero. It raises its match output for exactly one cycle, in the cycle its value reads zero, so the match period is (compare+1) source ticks.
- R6: In cascade mode, the second counter advances when the first counter passes from 0xFF to 0x00. A match occurs only when the first counter's count arrives while both halves equal {cmp1_i,cmp0_i}. That match clears both counters and pulses `match1_o`, giving a period of (cmp16+1) first-counter source ticks, while `match0_o` stays low.
- R7: The external pin passes through a two-stage synchronizer. Each rising edge yields exactly one count, however long the pin stays high.
- R8: While `rst` is 1, both counters read zero and both match outputs are low, whatever the run bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick_i | input | 1 | Base clock enable feeding the prescaler |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| pre_run_i | input | 1 | Prescaler run; 0 stops and clears it |
| run0_i | input | 1 | First counter run; 0 stops and clears it |
| run1_i | input | 1 | Second counter run; 0 stops and clears it |
| cascade_i | input | 1 | 1 chains both counters into one 16-bit timer |
| src0_sel_i | input | 2 | First counter source code |
| src1_sel_i | input | 2 | Second counter source code (8-bit mode) |
| cmp0_i | input | CNT_W | First counter compare value (low half in cascade) |
| cmp1_i | input | CNT_W | Second counter compare value (high half in cascade) |
| cnt0_o | output | CNT_W | Live value of the first counter |
| cnt1_o | output | CNT_W | Live value of the second counter |
| match0_o | output | 1 | One-cycle match pulse of the first counter |
| match1_o | output | 1 | One-cycle match pulse of the second counter or of the 16-bit pair |

## Verification
The bench measures match periods in base ticks for every source code, including under a thinned base tick. A wrong tap position or an off-by-one in the compare-and-clear would show up as a period one tick or one divide step away from the expected value. Compare values of 0 and 0xFF are exercised; a counter that cleared on the wrong count would lose the period of 1 or overrun to 257. Two restart cases are checked: the prescaler's exact restart phase after a stop, and a run bit cleared mid-count. A prescaler that only paused instead of clearing would produce the first tick early. In cascade mode the bench checks 16-bit periods on both sides of the 0xFF carry and confirms `match0_o` stays silent. A long high level on the external pin must count once; a level-sensitive design would run away.

// File: rtl/dit_pkg.sv
package dit_pkg;

   // number of prescaler taps and their positions in the tap vector
   localparam int NTAP     = 4;
   localparam int TAP_T1   = 0;
   localparam int TAP_T4   = 1;
   localparam int TAP_T16  = 2;
   localparam int TAP_T256 = 3;

   // source codes of the first counter
   typedef enum logic [1:0] {
      SRC0_EXT = 2'b00,
      SRC0_T1  = 2'b01,
      SRC0_T4  = 2'b10,
      SRC0_T16 = 2'b11
   } src0_e;

   // source codes of the second counter in 8-bit mode
   typedef enum logic [1:0] {
      SRC1_M0   = 2'b00,
      SRC1_T1   = 2'b01,
      SRC1_T16  = 2'b10,
      SRC1_T256 = 2'b11
   } src1_e;

endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler
   import dit_pkg::*;
#(
   parameter int PRE_W = 9,
   parameter int TAP0  = 1,
   parameter int TAP1  = 3,
   parameter int TAP2  = 5,
   parameter int TAP3  = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             base_tick_i,
   input  logic             run_i,
   output logic [PRE_W-1:0] cnt_o,
   output logic [NTAP-1:0]  tick_o
);

   localparam int TAP_LEN [NTAP] = '{TAP0, TAP1, TAP2, TAP3};

   generate
      if (TAP0 < 1 || TAP0 >= TAP1 || TAP1 >= TAP2 || TAP2 >= TAP3 || TAP3 > PRE_W) begin : g_bad_taps
         $error("dit_prescaler: taps must rise strictly and fit in PRE_W");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i) begin
         cnt_q <= '0;
      end else if (base_tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // a tap fires on the base tick that rolls its low bits over
   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      localparam int LEN = TAP_LEN[g];
      assign tick_o[g] = base_tick_i & run_i & (&cnt_q[LEN-1:0]);
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dit_edge_sync: at least two synchronizer stages are needed");
      end
   endgenerate

   // STAGES synchronizer flops plus one history flop for the edge
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q <= '0;
      end else begin
         sh_q <= {sh_q[STAGES-1:0], pin_i};
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/dit_src_mux.sv
module dit_src_mux #(
   parameter int N     = 4,
   parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     src_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             run_i,
   output logic             en_o
);

   generate
      if ((1 << SEL_W) != N) begin : g_bad_n
         $error("dit_src_mux: N must be a power of two matching SEL_W");
      end
   endgenerate

   assign en_o = run_i & src_i[sel_i];

endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run_i,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("dit_counter: width must be positive");
      end
   endgenerate

   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst || !run_i) begin
         q_r <= '0;
      end else if (clr_i) begin
         q_r <= '0;
      end else if (inc_i) begin
         q_r <= q_r + 1'b1;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             base_tick_i,
   input  logic             ext_cnt_i,
   input  logic             pre_run_i,
   input  logic             run0_i,
   input  logic             run1_i,
   input  logic             cascade_i,
   input  logic [1:0]       src0_sel_i,
   input  logic [1:0]       src1_sel_i,
   input  logic [CNT_W-1:0] cmp0_i,
   input  logic [CNT_W-1:0] cmp1_i,
   output logic [CNT_W-1:0] cnt0_o,
   output logic [CNT_W-1:0] cnt1_o,
   output logic             match0_o,
   output logic             match1_o
);

   localparam int NCH = 2;

   generate
      if (PRE_W < 9) begin : g_bad_pre
         $error("dual_interval_timer: prescaler must reach the /512 tap");
      end
   endgenerate

   logic [PRE_W-1:0]           pre_cnt;
   logic [NTAP-1:0]            tap;
   logic                       ext_rise;
   logic                       en0, en1;
   logic                       eq0, eq1, eq16, top0;
   logic                       ev_m0;
   logic [NCH-1:0]             run_v, inc_v, clr_v;
   logic [NCH-1:0][CNT_W-1:0]  cnt_v;
   logic                       match0_q, match1_q;

   dit_prescaler #(
      .PRE_W (PRE_W),
      .TAP0  (1),
      .TAP1  (3),
      .TAP2  (5),
      .TAP3  (9)
   ) u_pre (
      .clk         (clk),
      .rst         (rst),
      .base_tick_i (base_tick_i),
      .run_i       (pre_run_i),
      .cnt_o       (pre_cnt),
      .tick_o      (tap)
   );

   dit_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_ext (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (ext_cnt_i),
      .rise_o (ext_rise)
   );

   dit_src_mux #(.N(4)) u_mux0 (
      .src_i ({tap[TAP_T16], tap[TAP_T4], tap[TAP_T1], ext_rise}),
      .sel_i (src0_sel_i),
      .run_i (run0_i),
      .en_o  (en0)
   );

   dit_src_mux #(.N(4)) u_mux1 (
      .src_i ({tap[TAP_T256], tap[TAP_T16], tap[TAP_T1], ev_m0}),
      .sel_i (src1_sel_i),
      .run_i (run1_i),
      .en_o  (en1)
   );

   assign eq0   = (cnt_v[0] == cmp0_i);
   assign eq1   = (cnt_v[1] == cmp1_i);
   assign eq16  = eq0 & eq1;
   assign top0  = &cnt_v[0];
   assign ev_m0 = en0 & eq0 & ~cascade_i;

   always_comb begin
      run_v = {run1_i, run0_i};
      if (cascade_i) begin
         inc_v[0] = en0;
         clr_v[0] = en0 & eq16;
         inc_v[1] = en0 & top0;
         clr_v[1] = en0 & eq16;
      end else begin
         inc_v[0] = en0;
         clr_v[0] = ev_m0;
         inc_v[1] = en1;
         clr_v[1] = en1 & eq1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_cnt
      dit_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .run_i (run_v[c]),
         .inc_i (inc_v[c]),
         .clr_i (clr_v[c]),
         .q_o   (cnt_v[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         match0_q <= 1'b0;
         match1_q <= 1'b0;
      end else begin
         match0_q <= ev_m0;
         match1_q <= clr_v[1];
      end
   end

   assign cnt0_o   = cnt_v[0];
   assign cnt1_o   = cnt_v[1];
   assign match0_o = match0_q;
   assign match1_o = match1_q;

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
   parameter int CNT_W = 8,
   parameter int PRE_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             base_tick_i,
   input logic             pre_run_i,
   input logic             run0_i,
   input logic             run1_i,
   input logic             cascade_i,
   input logic [PRE_W-1:0] pre_cnt,
   input logic [CNT_W-1:0] cnt0_o,
   input logic [CNT_W-1:0] cnt1_o,
   input logic             match0_o,
   input logic             match1_o
);

   // R1: a stopped prescaler is cleared
   a_r1_pre_stop_clear : assert property (@(posedge clk) disable iff (rst)
      !pre_run_i |=> (pre_cnt == '0));

   // R1: a running prescaler advances once per base tick
   a_r1_pre_step : assert property (@(posedge clk) disable iff (rst)
      (pre_run_i && base_tick_i) |=> (pre_cnt == $past(pre_cnt) + 1'b1));

   // R4: stopped counters read zero
   a_r4_run0_clear : assert property (@(posedge clk) disable iff (rst)
      !run0_i |=> (cnt0_o == '0));

   a_r4_run1_clear : assert property (@(posedge clk) disable iff (rst)
      !run1_i |=> (cnt1_o == '0));

   // R5: match pulses last one cycle and coincide with a cleared counter
   a_r5_match0_single : assert property (@(posedge clk) disable iff (rst)
      match0_o |=> !match0_o);

   a_r5_match1_single : assert property (@(posedge clk) disable iff (rst)
      match1_o |=> !match1_o);

   a_r5_match0_zero : assert property (@(posedge clk) disable iff (rst)
      match0_o |-> (cnt0_o == '0));

   a_r5_match1_zero : assert property (@(posedge clk) disable iff (rst)
      match1_o |-> (cnt1_o == '0));

   // R6: in cascade mode the low half never matches alone, and a 16-bit match clears both halves
   a_r6_no_low_match : assert property (@(posedge clk) disable iff (rst)
      cascade_i |=> !match0_o);

   a_r6_both_clear : assert property (@(posedge clk) disable iff (rst)
      ($past(cascade_i) && match1_o) |-> (cnt0_o == '0 && cnt1_o == '0));

   // R8: reset leaves the counters idle
   a_r8_reset_idle : assert property (@(posedge clk)
      rst |=> (cnt0_o == '0 && cnt1_o == '0 && !match0_o && !match1_o));

endmodule

bind dual_interval_timer dit_checker #(
   .CNT_W (CNT_W),
   .PRE_W (PRE_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .base_tick_i (base_tick_i),
   .pre_run_i   (pre_run_i),
   .run0_i      (run0_i),
   .run1_i      (run1_i),
   .cascade_i   (cascade_i),
   .pre_cnt     (pre_cnt),
   .cnt0_o      (cnt0_o),
   .cnt1_o      (cnt1_o),
   .match0_o    (match0_o),
   .match1_o    (match1_o)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             base_tick_i = 1'b0;
   logic             ext_cnt_i = 1'b0;
   logic             pre_run_i = 1'b0;
   logic             run0_i = 1'b0;
   logic             run1_i = 1'b0;
   logic             cascade_i = 1'b0;
   logic [1:0]       src0_sel_i = 2'b00;
   logic [1:0]       src1_sel_i = 2'b00;
   logic [CNT_W-1:0] cmp0_i = '0;
   logic [CNT_W-1:0] cmp1_i = '0;
   logic [CNT_W-1:0] cnt0_o, cnt1_o;
   logic             match0_o, match1_o;

   int total = 0;
   int bad   = 0;
   int density = 100;
   int acc0 = 0, acc1 = 0, per0 = 0, per1 = 0, np0 = 0, np1 = 0;
   bit arm0 = 0, arm1 = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dual_interval_timer #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst(rst), .base_tick_i(base_tick_i), .ext_cnt_i(ext_cnt_i),
      .pre_run_i(pre_run_i), .run0_i(run0_i), .run1_i(run1_i), .cascade_i(cascade_i),
      .src0_sel_i(src0_sel_i), .src1_sel_i(src1_sel_i), .cmp0_i(cmp0_i), .cmp1_i(cmp1_i),
      .cnt0_o(cnt0_o), .cnt1_o(cnt1_o), .match0_o(match0_o), .match1_o(match1_o)
   );

   function automatic int div0(int s);
      case (s)
         1: return 2;
         2: return 8;
         3: return 32;
         default: return 0;
      endcase
   endfunction

   function automatic int div1(int s);
      case (s)
         1: return 2;
         2: return 32;
         3: return 512;
         default: return 0;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: sample outputs after the edge, then set the next base tick and count it
   task automatic step();
      @(negedge clk);
      if (match0_o) begin
         if (arm0) per0 = acc0;
         acc0 = 0; arm0 = 1; np0++;
      end
      if (match1_o) begin
         if (arm1) per1 = acc1;
         acc1 = 0; arm1 = 1; np1++;
      end
      base_tick_i = (density >= 100) ? 1'b1 : ($urandom_range(99) < density);
      acc0 += int'(base_tick_i);
      acc1 += int'(base_tick_i);
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic clear_meas();
      acc0 = 0; acc1 = 0; per0 = -1; per1 = -1; np0 = 0; np1 = 0; arm0 = 0; arm1 = 0;
   endtask

   task automatic wait_pulses(int ch, int n, int limit);
      for (int i = 0; i < limit; i++) begin
         if ((ch == 0 ? np0 : np1) >= n) break;
         step();
      end
   endtask

   initial begin
      int seed_v;
      int c, s, n, v;
      seed_v = $urandom(32'd4711);
      // R8: run bits asserted while reset is held
      pre_run_i = 1; run0_i = 1; run1_i = 1; src0_sel_i = 2'b01; src1_sel_i = 2'b01;
      cmp0_i = 8'd3; cmp1_i = 8'd3;
      steps(6);
      check("R8 cnt0 in reset", int'(cnt0_o), 0);
      check("R8 cnt1 in reset", int'(cnt1_o), 0);
      check("R8 match in reset", int'(match0_o | match1_o), 0);
      run0_i = 0; run1_i = 0;
      rst = 0;
      steps(2);
      check("R8 cnt0 after reset", int'(cnt0_o), 0);

      // R2 / R5: first counter, every tap code
      for (int k = 1; k <= 3; k++) begin
         run0_i = 0; step();
         c = $urandom_range(k == 1 ? 9 : (k == 2 ? 5 : 3));
         cmp0_i = c[7:0]; src0_sel_i = k[1:0]; run0_i = 1;
         clear_meas(); wait_pulses(0, 3, 8000);
         check($sformatf("R2 R5 period src0=%0d", k), per0, (c + 1) * div0(k));
      end

      // R5 corners: compare 0 and 0xFF
      run0_i = 0; step(); cmp0_i = 8'd0; src0_sel_i = 2'b01; run0_i = 1;
      clear_meas(); wait_pulses(0, 3, 2000);
      check("R5 period cmp=0", per0, 2);
      run0_i = 0; step(); cmp0_i = 8'hFF; run0_i = 1;
      clear_meas(); wait_pulses(0, 3, 4000);
      check("R5 period cmp=255", per0, 512);

      // R3: second counter tap codes
      for (int k = 1; k <= 3; k++) begin
         run1_i = 0; step();
         c = $urandom_range(k == 1 ? 9 : (k == 2 ? 5 : 1));
         cmp1_i = c[7:0]; src1_sel_i = k[1:0]; run1_i = 1;
         clear_meas(); wait_pulses(1, 3, 8000);
         check($sformatf("R3 R5 period src1=%0d", k), per1, (c + 1) * div1(k));
      end

      // R3: second counter fed by first counter matches
      run0_i = 0; run1_i = 0; step();
      src0_sel_i = 2'b01; cmp0_i = 8'd4; src1_sel_i = 2'b00; cmp1_i = 8'd2;
      run0_i = 1; run1_i = 1;
      clear_meas(); wait_pulses(1, 3, 2000);
      check("R3 chained match period", per1, 5 * 3 * 2);

      // R1 / R2: thinned base tick, constrained-random codes
      for (int t = 0; t < 6; t++) begin
         density = 30 + $urandom_range(60);
         s = 1 + $urandom_range(2);
         c = $urandom_range(s == 3 ? 2 : 6);
         run0_i = 0; run1_i = 0; step();
         src0_sel_i = s[1:0]; cmp0_i = c[7:0]; run0_i = 1;
         clear_meas(); wait_pulses(0, 3, 12000);
         check($sformatf("R1 R2 thinned period src0=%0d", s), per0, (c + 1) * div0(s));
      end
      density = 100;

      // R4: mid-count stop of the first counter leaves the second running
      run0_i = 0; run1_i = 0; step();
      src0_sel_i = 2'b11; cmp0_i = 8'd200; src1_sel_i = 2'b01; cmp1_i = 8'd200;
      run0_i = 1; run1_i = 1;
      steps(100);
      v = int'(cnt1_o);
      run0_i = 0; step();
      check("R4 cnt0 cleared by run0=0", int'(cnt0_o), 0);
      check("R4 cnt1 keeps counting", int'(cnt1_o >= v[7:0] && cnt1_o != 0), 1);
      steps(10);
      check("R4 cnt0 stays zero", int'(cnt0_o), 0);

      // R1: prescaler stop clears its phase
      pre_run_i = 0; steps(3);
      pre_run_i = 1; run0_i = 1;
      steps(31);
      check("R1 no /32 tick before 32 base ticks", int'(cnt0_o), 0);
      step();
      check("R1 first /32 tick on 32nd base tick", int'(cnt0_o), 1);
      pre_run_i = 0; steps(100);
      check("R1 stopped prescaler gives no ticks", int'(cnt0_o), 1);
      pre_run_i = 1;

      // R6: cascade periods around the carry
      run0_i = 0; run1_i = 0; step();
      cascade_i = 1; src0_sel_i = 2'b01; cmp0_i = 8'h05; cmp1_i = 8'h01;
      run0_i = 1; run1_i = 1;
      clear_meas(); wait_pulses(1, 3, 4000);
      check("R6 cascade period 0x0105", per1, (16'h0105 + 1) * 2);
      check("R6 no low-half match", np0, 0);
      run0_i = 0; run1_i = 0; step();
      cmp0_i = 8'hFF; cmp1_i = 8'h00; run0_i = 1; run1_i = 1;
      clear_meas(); wait_pulses(1, 3, 4000);
      check("R6 cascade period 0x00FF", per1, 256 * 2);
      run0_i = 0; run1_i = 0; step();
      c = 256 + $urandom_range(400);
      cmp0_i = c[7:0]; cmp1_i = c[15:8]; src0_sel_i = 2'b01; run0_i = 1; run1_i = 1;
      clear_meas(); wait_pulses(1, 3, 6000);
      check("R6 cascade random period", per1, (c + 1) * 2);
      check("R6 no low-half match random", np0, 0);

      // R7: external pin edges
      run0_i = 0; run1_i = 0; cascade_i = 0; step();
      src0_sel_i = 2'b00; cmp0_i = 8'hFF; run0_i = 1;
      n = 5 + $urandom_range(10);
      for (int e = 0; e < n; e++) begin
         ext_cnt_i = 1; steps(1 + $urandom_range(3));
         ext_cnt_i = 0; steps(1 + $urandom_range(3));
      end
      steps(4);
      check("R7 one count per rising edge", int'(cnt0_o), n);
      ext_cnt_i = 1; steps(40);
      check("R7 long high level counts once", int'(cnt0_o), n + 1);
      ext_cnt_i = 0; steps(4);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule